// File: doc/BRIEF.md
# Walking-Bit Data Bus Self-Test with Blink-Code Fault Report

This block exercises every line of a wide data path after power-up. Once started, it drives a sequence of test words onto its pattern output, lets each word settle through whatever device sits behind the bus, and compares the word that comes back on the loopback input. It runs a walking-one sweep first and then a walking-zero sweep, so a line held high and a line held low are both caught. It also catches coupling faults that only appear when all other lines are high.

When every step matches, the block raises its done and pass flags. At the first mismatch it stops. It latches the lowest mismatching line and reports that line on a single status LED as a repeating four-digit blink code. The leading digits are a fixed 4, 1, 1. The last digit is the failing line number plus one. While the test runs, or after a clean pass, the same LED stays lit steadily to show that the engine is alive. A technician can read the fault without any register access, and the numeric index is also available on a port.

Top module: `walk_bus_selftest`

## Requirements
- R1: A synchronous active-low reset clears all state. While in reset and on the cycle after it, `led_o`, `done_o`, `pass_o`, `fail_o`, `bad_line_o` and `pat_o` are all zero.
- R2: After a start pulse, `pat_o` presents the words 1<<i for i = 0 up to DATA_W-1 in ascending order, and then the words ~(1<<i) for i = 0 up to DATA_W-1 in ascending order. No other nonzero word appears.
- R3: The walking-zero sweep compares every line. A fault that alters line k only while the word ~(1<<k) is driven is reported as line k.
- R4: Each step holds its word for one settle cycle and one compare cycle. If the start input is high at clock edge 0, the compare of step j happens at edge 2j+2, and a clean run raises `done_o` after edge 2*(2*DATA_W).
- R5: On a mismatch, `bad_line_o` is the lowest set bit of (driven word XOR read-back word). No later step runs, and `pat_o` returns to zero.
- R6: After a failure, `fail_o`, `done_o` and `bad_line_o` hold until reset. A start pulse during the fault display changes neither the flags, the index, `pat_o`, nor the running blink code.
- R7: While failed, the LED shows the digits 4, 1, 1, then (`bad_line_o`+1), and repeats them. A digit N is N pulses, each high for BLINK_ON cycles and then low for BLINK_OFF cycles.
- R8: After the last pulse of a digit, the LED stays low for BLINK_OFF+GAP_DIGIT cycles. After the fourth digit it stays low for BLINK_OFF+GAP_CODE cycles before the code starts again.
- R9: While the test runs and after a clean pass, `led_o` is held high without interruption.
- R10: `pass_o` rises only after all 2*DATA_W steps match, and never together with `fail_o`. A start pulse after a pass clears `pass_o` and runs the whole test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle or passed |
| pat_o | output | DATA_W | Test word driven onto the bus |
| rdbk_i | input | DATA_W | Word read back through the loopback |
| led_o | output | 1 | Status LED: steady when alive, blink code on fault |
| done_o | output | 1 | Test finished (pass or fail) |
| pass_o | output | 1 | All steps matched |
| fail_o | output | 1 | A mismatch was found |
| bad_line_o | output | clog2(DATA_W) | Lowest failing line index |

## Verification
The bench builds the block at its full width of 32 lines, so both sweeps and the largest last digit of 32 pulses are covered. The blink timing is shortened to 2 cycles on, 3 off, a digit gap of 6 and a code gap of 11. With these values, two full repetitions of even the longest code fit in a few hundred cycles. Pulse widths, digit gaps and the code gap all have different lengths, so each can be measured on its own at the LED pin. Faults are injected in the loopback model as stuck-high lines, stuck-low lines, multiple lines and a coupling fault seen only by the walking-zero sweep.

// File: rtl/walk_test_pkg.sv
// Shared types for the walking-bit bus self-test.
// Assumes: nothing beyond standard SystemVerilog enums.
package walk_test_pkg;

    // Sequencer states of the pattern engine
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_CMP,
        SQ_PASS,
        SQ_FAIL
    } seq_state_e;

    // Phases of the blink-code generator
    typedef enum logic [1:0] {
        BL_IDLE,
        BL_ON,
        BL_OFF,
        BL_GAP
    } blink_state_e;

    // Fixed value of the leading digit of the fault code
    localparam int unsigned LEAD_DIGIT = 4;

endpackage

// File: rtl/walk_lsb_enc.sv
// Lowest-set-bit finder.
// Returns the index of the least significant 1 in vec, plus a hit flag.
// Assumes: idx is meaningless when hit is low (it reads zero then).
module walk_lsb_enc #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);

    // Priority scan from the top so the lowest set bit wins last
    always_comb begin
        idx = '0;
        hit = |vec;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/walk_seq.sv
// Pattern sequencer: runs the walking-one sweep and then the walking-zero sweep.
// Each step registers the word, waits one settle cycle, and compares in the next.
// Stops at the first mismatch and latches the lowest failing line.
// Assumes: rdbk is valid one cycle after pat changes (loopback delay < 1 cycle).
module walk_seq
    import walk_test_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] rdbk,
    output logic [DATA_W-1:0] pat,
    output logic              busy,
    output logic              pass,
    output logic              fail,
    output logic [IDX_W-1:0]  bad_line
);

    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(DATA_W - 1);

    seq_state_e        state;
    logic              zero_ph;
    logic [IDX_W-1:0]  pos;
    logic [DATA_W-1:0] diff;
    logic [IDX_W-1:0]  diff_idx;
    logic              diff_hit;

    // Walking word for a sweep phase and bit position
    function automatic logic [DATA_W-1:0] walk_word(input logic zp,
                                                    input logic [IDX_W-1:0] p);
        logic [DATA_W-1:0] one;
        one = DATA_W'(1) << p;
        return zp ? ~one : one;
    endfunction

    // Mismatch vector between driven and returned word
    assign diff = pat ^ rdbk;

    walk_lsb_enc #(.W(DATA_W), .IDX_W(IDX_W)) u_lsb (
        .vec (diff),
        .idx (diff_idx),
        .hit (diff_hit)
    );

    // Step sequencing, comparison and result latching
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            zero_ph  <= 1'b0;
            pos      <= '0;
            pat      <= '0;
            bad_line <= '0;
        end else begin
            unique case (state)
                SQ_IDLE, SQ_PASS: begin
                    if (start) begin
                        zero_ph <= 1'b0;
                        pos     <= '0;
                        pat     <= walk_word(1'b0, '0);
                        state   <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: state <= SQ_CMP;
                SQ_CMP: begin
                    if (diff_hit) begin
                        bad_line <= diff_idx;
                        pat      <= '0;
                        state    <= SQ_FAIL;
                    end else if (zero_ph && pos == LAST_POS) begin
                        pat   <= '0;
                        state <= SQ_PASS;
                    end else if (pos == LAST_POS) begin
                        zero_ph <= 1'b1;
                        pos     <= '0;
                        pat     <= walk_word(1'b1, '0);
                        state   <= SQ_SETTLE;
                    end else begin
                        pos   <= pos + 1'b1;
                        pat   <= walk_word(zero_ph, pos + 1'b1);
                        state <= SQ_SETTLE;
                    end
                end
                SQ_FAIL: state <= SQ_FAIL;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Status decode from the state register
    assign busy = (state == SQ_SETTLE) || (state == SQ_CMP);
    assign pass = (state == SQ_PASS);
    assign fail = (state == SQ_FAIL);

    // R6: a failure persists and its index never moves
    p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail && $stable(bad_line));

    // R10: pass and fail are exclusive
    p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R2: walking-one words carry exactly one high line
    p_one_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !zero_ph) |-> $countones(pat) == 1);

    // R2: walking-zero words carry exactly one low line
    p_zero_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && zero_ph) |-> $countones(~pat) == 1);

    // R4: the word is held from settle into compare
    p_settle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SETTLE) |=> $stable(pat) && state == SQ_CMP);

    // R5: entering failure clears the bus
    p_fail_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> pat == '0);

endmodule

// File: rtl/walk_blink.sv
// Blink-code generator: while enabled, pulses the LED as four digits
// (LEAD_DIGIT, 1, 1, last_digit) and repeats them, with a short pause between
// digits and a long pause between codes.
// Assumes: all timing parameters >= 1, last_digit >= 1 and stable while enabled.
module walk_blink
    import walk_test_pkg::*;
#(
    parameter int unsigned BLINK_ON  = 4,
    parameter int unsigned BLINK_OFF = 4,
    parameter int unsigned GAP_DIGIT = 12,
    parameter int unsigned GAP_CODE  = 30,
    parameter int unsigned DIG_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIG_W-1:0] last_digit,
    output logic             led
);

    localparam int unsigned MAX_AB = (BLINK_ON > BLINK_OFF) ? BLINK_ON : BLINK_OFF;
    localparam int unsigned MAX_CD = (GAP_DIGIT > GAP_CODE) ? GAP_DIGIT : GAP_CODE;
    localparam int unsigned MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CNT_W  = $clog2(MAX_T + 1);

    blink_state_e     bstate;
    logic [CNT_W-1:0] cnt;
    logic [DIG_W-1:0] pulse;
    logic [1:0]       dpos;
    logic [DIG_W-1:0] cur_digit;

    // Value of the digit currently shown
    always_comb begin
        unique case (dpos)
            2'd0:    cur_digit = DIG_W'(LEAD_DIGIT);
            2'd3:    cur_digit = last_digit;
            default: cur_digit = DIG_W'(1);
        endcase
    end

    // Pulse, digit and code timing
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bstate <= BL_IDLE;
            cnt    <= '0;
            pulse  <= '0;
            dpos   <= '0;
        end else begin
            unique case (bstate)
                BL_IDLE: begin
                    bstate <= BL_ON;
                    cnt    <= CNT_W'(BLINK_ON - 1);
                    pulse  <= DIG_W'(1);
                    dpos   <= '0;
                end
                BL_ON: begin
                    if (cnt == '0) begin
                        bstate <= BL_OFF;
                        cnt    <= CNT_W'(BLINK_OFF - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BL_OFF: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (pulse < cur_digit) begin
                        pulse  <= pulse + 1'b1;
                        bstate <= BL_ON;
                        cnt    <= CNT_W'(BLINK_ON - 1);
                    end else begin
                        bstate <= BL_GAP;
                        cnt    <= (dpos == 2'd3) ? CNT_W'(GAP_CODE - 1)
                                                 : CNT_W'(GAP_DIGIT - 1);
                    end
                end
                BL_GAP: begin
                    if (cnt == '0) begin
                        dpos   <= dpos + 1'b1;
                        pulse  <= DIG_W'(1);
                        bstate <= BL_ON;
                        cnt    <= CNT_W'(BLINK_ON - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: bstate <= BL_IDLE;
            endcase
        end
    end

    // LED is lit only inside a pulse
    assign led = (bstate == BL_ON);

    // R7: the pulse count never exceeds the digit being shown
    p_pulse_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bstate != BL_IDLE) |-> (pulse >= DIG_W'(1) && pulse <= cur_digit));

    // R1: a disabled generator leaves the LED dark
    p_dark_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !led);

    // R8: leaving a pause always starts a fresh first pulse
    p_gap_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bstate == BL_GAP && cnt == '0) |=> (!en || (led && pulse == DIG_W'(1))));

endmodule

// File: rtl/walk_bus_selftest.sv
// Top of the data bus self-test. Joins the pattern sequencer and the
// blink-code generator and selects what the single status LED shows.
// Assumes: the device behind pat_o/rdbk_i answers within one clock cycle.
module walk_bus_selftest #(
    parameter  int unsigned DATA_W    = 32,
    parameter  int unsigned BLINK_ON  = 4,
    parameter  int unsigned BLINK_OFF = 4,
    parameter  int unsigned GAP_DIGIT = 12,
    parameter  int unsigned GAP_CODE  = 30,
    localparam int unsigned IDX_W     = $clog2(DATA_W),
    localparam int unsigned DIG_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [DATA_W-1:0] pat_o,
    input  logic [DATA_W-1:0] rdbk_i,
    output logic              led_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [IDX_W-1:0]  bad_line_o
);

    logic             busy;
    logic             blink_led;
    logic [DIG_W-1:0] code_digit;

    walk_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .rdbk     (rdbk_i),
        .pat      (pat_o),
        .busy     (busy),
        .pass     (pass_o),
        .fail     (fail_o),
        .bad_line (bad_line_o)
    );

    // Last digit of the code is the line number plus one
    assign code_digit = DIG_W'(bad_line_o) + DIG_W'(1);

    walk_blink #(
        .BLINK_ON  (BLINK_ON),
        .BLINK_OFF (BLINK_OFF),
        .GAP_DIGIT (GAP_DIGIT),
        .GAP_CODE  (GAP_CODE),
        .DIG_W     (DIG_W)
    ) u_blink (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (fail_o),
        .last_digit (code_digit),
        .led        (blink_led)
    );

    // LED source: blink code on fault, steady while alive, dark when idle
    assign led_o  = fail_o ? blink_led : (busy || pass_o);
    assign done_o = pass_o || fail_o;

endmodule

// File: tb/walk_bus_selftest_tb_top.sv
module walk_bus_selftest_tb_top;

    localparam int unsigned DW   = 32;
    localparam int unsigned B_ON = 2;
    localparam int unsigned B_OF = 3;
    localparam int unsigned G_DG = 6;
    localparam int unsigned G_CD = 11;
    localparam int unsigned STEPS = 2 * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] pat_o;
    logic [DW-1:0] rdbk_i;
    logic          led_o, done_o, pass_o, fail_o;
    logic [4:0]    bad_line_o;

    // Loopback fault model
    logic [DW-1:0] f_hi = '0;
    logic [DW-1:0] f_lo = '0;
    logic          f_cp_en = 1'b0;
    int            f_cp_line = 0;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [DW-1:0] exp_pat[$];
    int            exp_dig[$];

    always #5 clk = ~clk;

    always_comb begin
        rdbk_i = (pat_o | f_hi) & ~f_lo;
        if (f_cp_en && pat_o == ~(32'h1 << f_cp_line))
            rdbk_i = rdbk_i | (32'h1 << f_cp_line);
    end

    walk_bus_selftest #(
        .DATA_W(DW), .BLINK_ON(B_ON), .BLINK_OFF(B_OF),
        .GAP_DIGIT(G_DG), .GAP_CODE(G_CD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pat_o(pat_o),
        .rdbk_i(rdbk_i), .led_o(led_o), .done_o(done_o), .pass_o(pass_o),
        .fail_o(fail_o), .bad_line_o(bad_line_o)
    );

    task automatic chk(input bit ok, input string req,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    // Pattern monitor: pops expected words as new ones appear (R2)
    logic [DW-1:0] p_last = '0;
    always @(negedge clk) begin
        if (!rst_n) p_last = '0;
        else if (pat_o != p_last) begin
            p_last = pat_o;
            if (pat_o != '0) begin
                if (exp_pat.size() == 0) chk(1'b0, "R2 extra word", pat_o, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_pat.pop_front();
                    chk(pat_o == e, "R2 word order", pat_o, e);
                end
            end
        end
    end

    // Blink monitor: decodes LED runs into digits and checks timing (R7, R8)
    bit d_prev;
    int d_on, d_off, d_pulses, d_pos, d_gap_exp;
    bit d_gap_pend;
    always @(negedge clk) begin
        if (!rst_n || !fail_o) begin
            d_prev = 0; d_on = 0; d_off = 0; d_pulses = 0;
            d_pos = 0; d_gap_pend = 0; d_gap_exp = 0;
        end else if (led_o) begin
            if (!d_prev) begin
                if (d_gap_pend) begin
                    chk(d_off == int'(B_OF) + d_gap_exp, "R8 pause length",
                        d_off, int'(B_OF) + d_gap_exp);
                    d_gap_pend = 0;
                end else if (d_pulses > 0) begin
                    chk(d_off == int'(B_OF), "R7 off time", d_off, B_OF);
                end
                d_pulses++;
                d_on = 0;
            end
            d_on++;
            d_off = 0;
            d_prev = 1;
        end else begin
            if (d_prev) chk(d_on == int'(B_ON), "R7 on time", d_on, B_ON);
            d_off++;
            d_prev = 0;
            if (d_off == int'(B_OF) + 1 && d_pulses > 0) begin
                if (exp_dig.size() > 0) begin
                    int e;
                    e = exp_dig.pop_front();
                    chk(d_pulses == e, "R7 digit value", d_pulses, e);
                end
                d_gap_exp = (d_pos == 3) ? int'(G_CD) : int'(G_DG);
                d_gap_pend = 1;
                d_pos = (d_pos + 1) % 4;
                d_pulses = 0;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_pat.delete();
        exp_dig.delete();
    endtask

    task automatic push_words(input int upto);
        for (int s = 0; s < upto; s++) begin
            if (s < int'(DW)) exp_pat.push_back(32'h1 << s);
            else exp_pat.push_back(~(32'h1 << (s - int'(DW))));
        end
    endtask

    // Pulses start and returns the negedge count at which done_o is seen
    task automatic run_once(output int n, output int dark);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        dark = 0;
        while (!done_o && n < 400) begin
            if (!led_o) dark++;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_fault(input logic [DW-1:0] hi, input logic [DW-1:0] lo,
                             input bit cp, input int cp_line,
                             input int exp_line, input int exp_step,
                             input bit poke, input string tag);
        int n, dark, wait_n;
        do_reset();
        f_hi = hi; f_lo = lo; f_cp_en = cp; f_cp_line = cp_line;
        push_words(exp_step + 1);
        for (int r = 0; r < 2; r++) begin
            exp_dig.push_back(4); exp_dig.push_back(1);
            exp_dig.push_back(1); exp_dig.push_back(exp_line + 1);
        end
        run_once(n, dark);
        chk(n == 2 * exp_step + 3, {"R4 fail timing ", tag}, n, 2 * exp_step + 3);
        chk(fail_o && !pass_o, {"R10 fail only ", tag}, {pass_o, fail_o}, 1);
        chk(bad_line_o == exp_line, {"R5 line ", tag}, bad_line_o, exp_line);
        chk(pat_o == '0, {"R5 bus cleared ", tag}, pat_o, 0);
        chk(exp_pat.size() == 0, {"R5 stop at first fail ", tag}, exp_pat.size(), 0);
        wait_n = 0;
        while (exp_dig.size() > 0 && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
            if (poke && exp_dig.size() == 6 && wait_n < 1000) begin
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(fail_o && bad_line_o == exp_line && pat_o == '0,
                    {"R6 start ignored ", tag}, bad_line_o, exp_line);
                wait_n = 1000;
            end
        end
        chk(exp_dig.size() == 0, {"R7 code observed ", tag}, exp_dig.size(), 0);
        chk(fail_o && done_o && bad_line_o == exp_line, {"R6 held ", tag},
            bad_line_o, exp_line);
        f_hi = '0; f_lo = '0; f_cp_en = 1'b0;
    endtask

    initial begin
        int n, dark;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({led_o, done_o, pass_o, fail_o} == 4'b0 && pat_o == '0 && bad_line_o == '0,
            "R1 reset outputs", {led_o, done_o, pass_o, fail_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!led_o && !done_o, "R1 idle after reset", led_o, 0);

        // Clean pass: order (R2), timing (R4), steady LED (R9), pass (R10)
        push_words(STEPS);
        run_once(n, dark);
        chk(n == 2 * STEPS + 1, "R4 clean run length", n, 2 * STEPS + 1);
        chk(pass_o && !fail_o && done_o, "R10 pass flag", {pass_o, fail_o}, 2);
        chk(dark == 0, "R9 LED steady while running", dark, 0);
        chk(exp_pat.size() == 0, "R2 all words seen", exp_pat.size(), 0);
        repeat (5) @(negedge clk);
        chk(led_o && pass_o, "R9 LED steady after pass", led_o, 1);

        // Restart from pass (R10)
        push_words(STEPS);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!pass_o && !done_o, "R10 pass cleared on restart", pass_o, 0);
        n = 1;
        while (!done_o && n < 400) begin @(negedge clk); n++; end
        chk(pass_o && n == 2 * STEPS + 1, "R10 second pass", n, 2 * STEPS + 1);

        // Faults
        run_fault(32'h0000_0100, '0, 0, 0, 8, 0, 1, "hi8");
        run_fault('0, 32'h0000_0001, 0, 0, 0, 0, 0, "lo0");
        run_fault('0, 32'h8000_0000, 0, 0, 31, 31, 0, "lo31");
        run_fault(32'h0010_0020, '0, 0, 0, 5, 0, 0, "hi5_20");
        run_fault('0, '0, 1, 12, 12, 32 + 12, 0, "R3 coupling12");

        // R1: reset during display
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!led_o && !fail_o && !done_o && bad_line_o == '0,
            "R1 reset during code", {led_o, fail_o, done_o}, 0);

        report();
    end

endmodule